// File: doc/BRIEF.md
# SDRAM Bank Tracking Table with Shared Slot Pool

This block records which SDRAM banks have a row open, and which row, across all chip selects of a memory system. It does not hold one entry for every bank. It keeps a small pool of tracking slots. A slot is claimed when a bank is activated and returned when that bank is precharged. This saves area when the memory has many banks. The pool only needs to be as deep as the command queue look-ahead, because the controller can never hold more pages open than that. The cost is some loss of page-hit efficiency when the pool is smaller than the number of banks.

The main state machine reports every activate, precharge, precharge-all and read/write command on one update port. One or more lookup ports answer from the current table, with no clock delay. For each query the answer is page hit, page miss or bank idle, together with the slot that holds the bank. If an activate targets an untracked bank while every slot is in use, the block raises a stall in the same cycle and ignores the command. The state machine must then precharge some bank first. A mode input selects a close-page policy, under which each read/write also closes its bank and frees the bank's slot.

Top module: `bank_track_table`

## Requirements
- R1: After reset every slot is empty, so every lookup reports idle (status 0) and the stall output is low.
- R2: A command is valid when `upd_valid_i` is high. Command codes are: 0 nop, 1 activate, 2 precharge, 3 precharge-all, 4 read/write. An activate to an untracked chip/bank claims the free slot with the lowest index. From the next cycle on, a lookup of that chip, bank and row reports hit (status 1) with that slot index.
- R3: A lookup of a tracked chip/bank with a different row reports miss (status 2) together with the slot index of that bank.
- R4: The same bank number on different chip selects is tracked as a separate entry.
- R5: A precharge to a tracked bank frees its slot, and the bank then reads idle. A later activate to a new bank reuses the lowest free slot.
- R6: An activate to an untracked bank while all slots are in use raises `act_stall_o` in the same cycle and leaves the table unchanged. An activate to an already tracked bank never stalls.
- R7: An activate to an already tracked bank replaces the stored row in the same slot and claims no new slot.
- R8: Precharge-all empties every slot in one cycle.
- R9: A read/write frees the slot of its bank when `close_page_i` is high. It leaves the bank open when `close_page_i` is low.
- R10: A precharge or read/write to an untracked bank changes no slot.
- R11: Each lookup port answers its own query independently of the other ports in the same cycle.
- R12: A lookup that finds no tracked bank reports slot index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| close_page_i | input | 1 | Close-page policy: a read/write frees its bank |
| upd_valid_i | input | 1 | An issued command is present |
| upd_cmd_i | input | 3 | Command code (0 nop, 1 act, 2 pre, 3 pre-all, 4 rd/wr) |
| upd_cs_i | input | CS_W | Chip select of the command |
| upd_bank_i | input | BANK_W | Bank of the command |
| upd_row_i | input | ROW_W | Row of an activate |
| act_stall_o | output | 1 | Activate cannot be tracked: no free slot |
| lk_cs_i | input | NUM_LK*CS_W | Chip select per lookup port |
| lk_bank_i | input | NUM_LK*BANK_W | Bank per lookup port |
| lk_row_i | input | NUM_LK*ROW_W | Row per lookup port |
| lk_stat_o | output | NUM_LK*2 | Status per port: 0 idle, 1 hit, 2 miss |
| lk_slot_o | output | NUM_LK*SLOT_W | Matching slot per port, 0 when idle |

## Verification
Any corrupted slot shows up at the lookup ports one cycle after the command that caused it. A lost allocation reads idle where a hit is expected. A stale row reads hit where a miss is expected. A wrong free-slot choice reads back as an unexpected slot index. Leaked slots do not show up at once. They appear later, as an early stall on the activate that should have found a free slot. For this reason the directed tests fill the pool to the limit, then free and reuse slots, and check the slot indices the whole time.

// File: rtl/bank_track_pkg.sv
package bank_track_pkg;
  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_ACT     = 3'd1,
    CMD_PRE     = 3'd2,
    CMD_PRE_ALL = 3'd3,
    CMD_RW      = 3'd4
  } bt_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIT  = 2'd1,
    ST_MISS = 2'd2
  } bt_stat_e;
endpackage

// File: rtl/bt_slot.sv
module bt_slot #(
  parameter int KEY_W = 4,
  parameter int ROW_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             vld_o,
  output logic [KEY_W-1:0] key_o,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      key_o <= '0;
      row_o <= '0;
    end else if (clr_i) begin
      vld_o <= 1'b0;
    end else if (set_i) begin
      vld_o <= 1'b1;
      key_o <= key_i;
      row_o <= row_i;
    end
  end
endmodule

// File: rtl/bt_match.sv
module bt_match #(
  parameter int NUM_SLOTS = 4,
  parameter int KEY_W     = 4,
  parameter int ROW_W     = 14,
  parameter int SLOT_W    = 2
) (
  input  logic [NUM_SLOTS-1:0]       vld_i,
  input  logic [NUM_SLOTS*KEY_W-1:0] key_i,
  input  logic [NUM_SLOTS*ROW_W-1:0] row_i,
  input  logic [KEY_W-1:0]           q_key_i,
  input  logic [ROW_W-1:0]           q_row_i,
  output logic                       found_o,
  output logic [SLOT_W-1:0]          idx_o,
  output logic                       row_eq_o
);
  // keys are unique among valid slots, so at most one matches
  always_comb begin
    found_o  = 1'b0;
    idx_o    = '0;
    row_eq_o = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (vld_i[s] && key_i[s*KEY_W +: KEY_W] == q_key_i) begin
        found_o  = 1'b1;
        idx_o    = SLOT_W'(s);
        row_eq_o = (row_i[s*ROW_W +: ROW_W] == q_row_i);
      end
    end
  end
endmodule

// File: rtl/bt_free_pick.sv
module bt_free_pick #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2
) (
  input  logic [NUM_SLOTS-1:0] vld_i,
  output logic                 any_free_o,
  output logic [SLOT_W-1:0]    idx_o
);
  always_comb begin
    any_free_o = 1'b0;
    idx_o      = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (!vld_i[s]) begin
        any_free_o = 1'b1;
        idx_o      = SLOT_W'(s);
      end
    end
  end
endmodule

// File: rtl/bank_track_table.sv
module bank_track_table
  import bank_track_pkg::*;
#(
  parameter int NUM_CS    = 2,
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int NUM_SLOTS = 4,
  parameter int NUM_LK    = 2,
  localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     close_page_i,
  input  logic                     upd_valid_i,
  input  logic [2:0]               upd_cmd_i,
  input  logic [CS_W-1:0]          upd_cs_i,
  input  logic [BANK_W-1:0]        upd_bank_i,
  input  logic [ROW_W-1:0]         upd_row_i,
  output logic                     act_stall_o,
  input  logic [NUM_LK*CS_W-1:0]   lk_cs_i,
  input  logic [NUM_LK*BANK_W-1:0] lk_bank_i,
  input  logic [NUM_LK*ROW_W-1:0]  lk_row_i,
  output logic [NUM_LK*2-1:0]      lk_stat_o,
  output logic [NUM_LK*SLOT_W-1:0] lk_slot_o
);
  localparam int KEY_W = CS_W + BANK_W;

  logic [NUM_SLOTS-1:0]       slot_vld;
  logic [NUM_SLOTS*KEY_W-1:0] slot_key;
  logic [NUM_SLOTS*ROW_W-1:0] slot_row;
  logic [NUM_SLOTS-1:0]       slot_set;
  logic [NUM_SLOTS-1:0]       slot_clr;

  bt_cmd_e          cmd;
  logic [KEY_W-1:0] upd_key;
  logic             upd_found, upd_row_eq, any_free;
  logic [SLOT_W-1:0] upd_idx, free_idx;
  logic             is_act, is_pre, is_pall, is_rw;

  assign cmd     = bt_cmd_e'(upd_cmd_i);
  assign upd_key = {upd_cs_i, upd_bank_i};
  assign is_act  = upd_valid_i && cmd == CMD_ACT;
  assign is_pre  = upd_valid_i && cmd == CMD_PRE;
  assign is_pall = upd_valid_i && cmd == CMD_PRE_ALL;
  assign is_rw   = upd_valid_i && cmd == CMD_RW;

  bt_match #(
    .NUM_SLOTS(NUM_SLOTS), .KEY_W(KEY_W), .ROW_W(ROW_W), .SLOT_W(SLOT_W)
  ) u_upd_match (
    .vld_i(slot_vld), .key_i(slot_key), .row_i(slot_row),
    .q_key_i(upd_key), .q_row_i(upd_row_i),
    .found_o(upd_found), .idx_o(upd_idx), .row_eq_o(upd_row_eq)
  );

  bt_free_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_free (
    .vld_i(slot_vld), .any_free_o(any_free), .idx_o(free_idx)
  );

  assign act_stall_o = is_act && !upd_found && !any_free;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic own;
    assign own = upd_found && upd_idx == SLOT_W'(s);
    // activate rewrites its own slot or claims the lowest free one
    assign slot_set[s] = is_act &&
                         (own || (!upd_found && any_free && free_idx == SLOT_W'(s)));
    assign slot_clr[s] = is_pall || (is_pre && own) ||
                         (is_rw && close_page_i && own);

    bt_slot #(.KEY_W(KEY_W), .ROW_W(ROW_W)) u_slot (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (slot_set[s]),
      .clr_i (slot_clr[s]),
      .key_i (upd_key),
      .row_i (upd_row_i),
      .vld_o (slot_vld[s]),
      .key_o (slot_key[s*KEY_W +: KEY_W]),
      .row_o (slot_row[s*ROW_W +: ROW_W])
    );
  end

  for (genvar p = 0; p < NUM_LK; p++) begin : g_lk
    logic             found, row_eq;
    logic [SLOT_W-1:0] idx;
    bt_stat_e         stat;

    bt_match #(
      .NUM_SLOTS(NUM_SLOTS), .KEY_W(KEY_W), .ROW_W(ROW_W), .SLOT_W(SLOT_W)
    ) u_lk_match (
      .vld_i(slot_vld), .key_i(slot_key), .row_i(slot_row),
      .q_key_i({lk_cs_i[p*CS_W +: CS_W], lk_bank_i[p*BANK_W +: BANK_W]}),
      .q_row_i(lk_row_i[p*ROW_W +: ROW_W]),
      .found_o(found), .idx_o(idx), .row_eq_o(row_eq)
    );

    always_comb begin
      if (!found)      stat = ST_IDLE;
      else if (row_eq) stat = ST_HIT;
      else             stat = ST_MISS;
    end

    assign lk_stat_o[p*2 +: 2]           = stat;
    assign lk_slot_o[p*SLOT_W +: SLOT_W] = idx;
  end

  logic unused_row_eq;
  assign unused_row_eq = upd_row_eq;
endmodule

// File: rtl/bank_track_table_chk.sv
module bank_track_table_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int KEY_W     = 4,
  parameter int SLOT_W    = 2,
  parameter int NUM_LK    = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       upd_valid_i,
  input logic [2:0]                 upd_cmd_i,
  input logic                       act_stall_o,
  input logic [NUM_SLOTS-1:0]       slot_vld,
  input logic [NUM_SLOTS*KEY_W-1:0] slot_key,
  input logic                       upd_found,
  input logic [SLOT_W-1:0]          upd_idx,
  input logic [NUM_LK*2-1:0]        lk_stat_o,
  input logic [NUM_LK*SLOT_W-1:0]   lk_slot_o
);
  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int a = 0; a < NUM_SLOTS; a++)
      for (int b = a + 1; b < NUM_SLOTS; b++)
        if (slot_vld[a] && slot_vld[b] &&
            slot_key[a*KEY_W +: KEY_W] == slot_key[b*KEY_W +: KEY_W])
          dup = 1'b1;
  end

  a_r2_unique_key: assert property (@(posedge clk_i) disable iff (!rst_ni) !dup);

  a_r2_hit_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_stat_o[1:0] == 2'd1) |-> slot_vld[lk_slot_o[SLOT_W-1:0]]);

  a_r6_stall_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_stall_o |-> (&slot_vld));

  a_r6_stall_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_stall_o |=> $stable(slot_vld) && $stable(slot_key));

  a_r5_pre_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_cmd_i == 3'd2 && upd_found) |=> !slot_vld[$past(upd_idx)]);

  a_r8_pre_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_cmd_i == 3'd3) |=> (slot_vld == '0));
endmodule

bind bank_track_table bank_track_table_chk #(
  .NUM_SLOTS(NUM_SLOTS), .KEY_W(KEY_W), .SLOT_W(SLOT_W), .NUM_LK(NUM_LK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .upd_valid_i(upd_valid_i), .upd_cmd_i(upd_cmd_i),
  .act_stall_o(act_stall_o), .slot_vld(slot_vld), .slot_key(slot_key),
  .upd_found(upd_found), .upd_idx(upd_idx), .lk_stat_o(lk_stat_o),
  .lk_slot_o(lk_slot_o)
);

// File: tb/bank_track_table_tb.sv
module bank_track_table_tb;
  localparam int NUM_CS = 2, NUM_BANKS = 8, ROW_W = 14, NUM_SLOTS = 4, NUM_LK = 2;
  localparam int CS_W = 1, BANK_W = 3, SLOT_W = 2;

  logic clk = 1'b0, rst_n = 1'b0, close_page = 1'b0;
  logic upd_valid = 1'b0;
  logic [2:0] upd_cmd = '0;
  logic [CS_W-1:0] upd_cs = '0;
  logic [BANK_W-1:0] upd_bank = '0;
  logic [ROW_W-1:0] upd_row = '0;
  logic act_stall;
  logic [NUM_LK*CS_W-1:0] lk_cs = '0;
  logic [NUM_LK*BANK_W-1:0] lk_bank = '0;
  logic [NUM_LK*ROW_W-1:0] lk_row = '0;
  logic [NUM_LK*2-1:0] lk_stat;
  logic [NUM_LK*SLOT_W-1:0] lk_slot;
  int checks = 0, fails = 0;
  logic last_stall;

  always #4 clk = ~clk;

  bank_track_table #(
    .NUM_CS(NUM_CS), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W),
    .NUM_SLOTS(NUM_SLOTS), .NUM_LK(NUM_LK)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .close_page_i(close_page),
    .upd_valid_i(upd_valid), .upd_cmd_i(upd_cmd), .upd_cs_i(upd_cs),
    .upd_bank_i(upd_bank), .upd_row_i(upd_row), .act_stall_o(act_stall),
    .lk_cs_i(lk_cs), .lk_bank_i(lk_bank), .lk_row_i(lk_row),
    .lk_stat_o(lk_stat), .lk_slot_o(lk_slot)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // cmd: 1 act, 2 pre, 3 pre-all, 4 rd/wr
  task automatic issue(int cmd, int cs, int bank, int row);
    @(negedge clk);
    upd_valid = 1'b1; upd_cmd = 3'(cmd); upd_cs = CS_W'(cs);
    upd_bank = BANK_W'(bank); upd_row = ROW_W'(row);
    #1 last_stall = act_stall;
    @(posedge clk);
    #1 upd_valid = 1'b0; upd_cmd = '0;
  endtask

  task automatic look(string req, int p, int cs, int bank, int row, int est, int eidx);
    lk_cs[p*CS_W +: CS_W] = CS_W'(cs);
    lk_bank[p*BANK_W +: BANK_W] = BANK_W'(bank);
    lk_row[p*ROW_W +: ROW_W] = ROW_W'(row);
    #1;
    chk({req, " status"}, int'(lk_stat[p*2 +: 2]), est);
    chk({req, " slot"}, int'(lk_slot[p*SLOT_W +: SLOT_W]), eidx);
  endtask

  task automatic t_reset();
    look("R1 idle p0", 0, 0, 3, 16'h100, 0, 0);
    look("R12 idle p1", 1, 1, 7, 5, 0, 0);
    chk("R1 stall low", int'(act_stall), 0);
  endtask

  task automatic t_alloc();
    issue(1, 0, 3, 'h100);
    chk("R2 no stall", int'(last_stall), 0);
    issue(1, 1, 3, 'h200);
    // R11: both ports queried at once
    lk_cs = {1'b1, 1'b0}; lk_bank = {3'd3, 3'd3}; lk_row = {14'h200, 14'h100};
    #1;
    chk("R11 port0 hit", int'(lk_stat[1:0]), 1);
    chk("R11 port0 slot", int'(lk_slot[1:0]), 0);
    chk("R4 port1 hit", int'(lk_stat[3:2]), 1);
    chk("R4 port1 slot", int'(lk_slot[3:2]), 1);
    look("R3 miss", 0, 0, 3, 'h101, 2, 0);
    look("R12 other bank", 0, 0, 4, 'h100, 0, 0);
  endtask

  task automatic t_reopen();
    issue(1, 0, 3, 'h55);
    look("R7 new row", 0, 0, 3, 'h55, 1, 0);
    look("R7 old row miss", 1, 0, 3, 'h100, 2, 0);
    issue(1, 0, 5, 'h7);
    look("R7 next slot", 0, 0, 5, 'h7, 1, 2);
  endtask

  task automatic t_full();
    issue(1, 1, 7, 'h3ff);
    look("R2 fourth slot", 0, 1, 7, 'h3ff, 1, 3);
    issue(1, 0, 0, 'h12);
    chk("R6 stall", int'(last_stall), 1);
    look("R6 untracked", 0, 0, 0, 'h12, 0, 0);
    look("R6 others kept", 1, 1, 3, 'h200, 1, 1);
    issue(1, 0, 5, 'h8);
    chk("R6 tracked no stall", int'(last_stall), 0);
    look("R6 tracked updated", 0, 0, 5, 'h8, 1, 2);
  endtask

  task automatic t_pre();
    issue(2, 1, 3, 0);
    look("R5 freed", 0, 1, 3, 'h200, 0, 0);
    issue(1, 0, 1, 'h9);
    chk("R5 no stall", int'(last_stall), 0);
    look("R5 reuse", 0, 0, 1, 'h9, 1, 1);
    issue(2, 1, 0, 0);
    issue(4, 1, 6, 0);
    look("R10 slot0", 0, 0, 3, 'h55, 1, 0);
    look("R10 slot1", 1, 0, 1, 'h9, 1, 1);
    look("R10 slot2", 0, 0, 5, 'h8, 1, 2);
    look("R10 slot3", 1, 1, 7, 'h3ff, 1, 3);
  endtask

  task automatic t_rw();
    close_page = 1'b0;
    issue(4, 0, 1, 'h9);
    look("R9 open page kept", 0, 0, 1, 'h9, 1, 1);
    close_page = 1'b1;
    issue(4, 0, 1, 'h9);
    look("R9 close page freed", 0, 0, 1, 'h9, 0, 0);
    look("R9 others kept", 1, 0, 5, 'h8, 1, 2);
    close_page = 1'b0;
  endtask

  task automatic t_pre_all();
    issue(3, 0, 0, 0);
    look("R8 slot0", 0, 0, 3, 'h55, 0, 0);
    look("R8 slot2", 1, 0, 5, 'h8, 0, 0);
    look("R8 slot3", 0, 1, 7, 'h3ff, 0, 0);
    issue(1, 1, 2, 'h3);
    look("R8 realloc", 0, 1, 2, 'h3, 1, 0);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #20;
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_alloc();
    t_reopen();
    t_full();
    t_pre();
    t_rw();
    t_pre_all();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule